// File: doc/BRIEF.md
# Layered Superstrip Road Finder

This block performs coarse pattern recognition for a tracking trigger. Hits arrive one per cycle on a valid/ready stream. Each hit carries a detector layer number (0 to 7), a fine cluster coordinate and an end-of-event marker. The block reduces the coordinate to a coarse superstrip identifier and compares it with every stored pattern at once. Each stored pattern holds one expected superstrip for each of the eight layers.

Every pattern keeps one sticky bit per layer. The bit records whether that layer has seen a matching superstrip during the current event. When the hit that carries the end-of-event marker has been taken, the block stops accepting input. It lists the index of each pattern whose count of set layer bits reaches a programmable threshold, one index per cycle. It then raises a one-cycle done flag, clears all layer bits and accepts the next event. Patterns are preloaded through a simple write port, one layer entry per write.

Top module: `am_road_finder`

## Requirements
- R1: After reset, in_ready is 1 and both road_valid and done are 0.
- R2: The superstrip of a hit is in_coord with its low 4 bits dropped, so coordinates that differ only in bits [3:0] match the same stored entry.
- R3: A pattern's bit for a layer is set by any accepted hit on that layer whose superstrip equals the stored entry for that layer. Repeated matches on one layer count once.
- R4: A pattern is a road when its number of set layer bits is greater than or equal to the threshold input (0 to 8). With threshold 7, seven matched layers fire and six do not.
- R5: One cycle after the edge that accepts a hit with in_last=1, the readout begins. Road indices then appear in ascending order, one per cycle with road_valid=1, and are followed by exactly one cycle with done=1.
- R6: Every layer bit is cleared at the end of the done cycle, and in_ready returns to 1 in the next cycle, so successive events do not mix.
- R7: From the edge that accepts an end-of-event hit until the done cycle has passed, in_ready is 0, and stream input has no effect.
- R8: A write with wr_en=1 stores wr_ss as the entry of pattern wr_addr for layer wr_layer, and later matches use the new value.
- R9: An event in which no pattern reaches the threshold produces done with no road_valid cycle.
- R10: The hit that carries in_last=1 is itself matched and counted for its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Hit present on the stream |
| in_ready | output | 1 | Block can accept a hit |
| in_layer | input | 3 | Detector layer of the hit |
| in_coord | input | 12 | Fine cluster coordinate |
| in_last | input | 1 | Hit closes the event |
| wr_en | input | 1 | Pattern entry write strobe |
| wr_addr | input | 4 | Pattern index to write |
| wr_layer | input | 3 | Layer entry to write |
| wr_ss | input | 8 | Superstrip value to store |
| threshold | input | 4 | Minimum matched layer count for a road |
| road_valid | output | 1 | road_id carries a road this cycle |
| road_id | output | 4 | Index of a matched pattern |
| done | output | 1 | Readout of the event is complete |

## Verification
The hardest case to reach is a hit that is offered while the readout is running: it must be neither taken nor counted. To create it, the bench keeps in_valid high with a matching, event-closing hit throughout a readout. It then sends a short event whose expected road list would change if those offered hits had leaked in. Sticky duplicates, a pattern rewrite that invalidates an old value, and a zero threshold are used to bring out the readout ordering across the full bank.

// File: rtl/am_road_pkg.sv
package am_road_pkg;

    localparam int unsigned NUM_LAYERS = 8;
    localparam int unsigned LAYER_W    = $clog2(NUM_LAYERS);
    localparam int unsigned COORD_W    = 12;
    localparam int unsigned SS_DROP    = 4;
    localparam int unsigned SS_W       = COORD_W - SS_DROP;
    localparam int unsigned CNT_W      = $clog2(NUM_LAYERS + 1);

    typedef logic [SS_W-1:0]    ss_t;
    typedef logic [LAYER_W-1:0] layer_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef struct packed {
        layer_t layer;
        ss_t    ss;
    } ss_hit_t;

    typedef enum logic [1:0] {
        ST_ACCEPT  = 2'd0,
        ST_LATCH   = 2'd1,
        ST_READOUT = 2'd2
    } ro_state_e;

    function automatic ss_t coord_to_ss(input logic [COORD_W-1:0] coord);
        return coord[COORD_W-1:SS_DROP];
    endfunction

    function automatic cnt_t count_flags(input logic [NUM_LAYERS-1:0] f);
        cnt_t n;
        n = '0;
        for (int i = 0; i < NUM_LAYERS; i++) begin
            n = n + cnt_t'(f[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/am_pattern_cell.sv
module am_pattern_cell
    import am_road_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  layer_t  wr_layer,
    input  ss_t     wr_ss,
    input  logic    hit_en,
    input  ss_hit_t hit,
    input  logic    clear,
    input  cnt_t    threshold,
    output logic    is_road
);

    ss_t                   stored [NUM_LAYERS];
    logic [NUM_LAYERS-1:0] flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NUM_LAYERS; l++) begin
                stored[l] <= '0;
            end
        end else if (wr_en) begin
            stored[wr_layer] <= wr_ss;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flags <= '0;
        end else if (hit_en && (stored[hit.layer] == hit.ss)) begin
            flags[hit.layer] <= 1'b1;
        end
    end

    always_comb begin
        is_road = (count_flags(flags) >= threshold);
    end

endmodule

// File: rtl/am_lowest_first.sv
module am_lowest_first #(
    parameter int unsigned N = 16,
    parameter int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/am_readout_ctrl.sv
module am_readout_ctrl
    import am_road_pkg::*;
#(
    parameter int unsigned NUM_PATTERNS = 16,
    parameter int unsigned PAT_W        = $clog2(NUM_PATTERNS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_last,
    input  logic [NUM_PATTERNS-1:0] road_vec,
    output logic                    in_ready,
    output logic                    accept,
    output logic                    clear_flags,
    output logic                    road_valid,
    output logic [PAT_W-1:0]        road_id,
    output logic                    done
);

    ro_state_e               state;
    logic [NUM_PATTERNS-1:0] pending;
    logic                    pend_any;
    logic [PAT_W-1:0]        pend_idx;

    am_lowest_first #(
        .N(NUM_PATTERNS),
        .W(PAT_W)
    ) enc_i (
        .req(pending),
        .any(pend_any),
        .idx(pend_idx)
    );

    always_comb begin
        in_ready    = (state == ST_ACCEPT);
        accept      = in_valid && in_ready;
        road_valid  = (state == ST_READOUT) && pend_any;
        road_id     = pend_idx;
        done        = (state == ST_READOUT) && !pend_any;
        clear_flags = done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_ACCEPT;
            pending <= '0;
        end else begin
            case (state)
                ST_ACCEPT: begin
                    if (accept && in_last) begin
                        state <= ST_LATCH;
                    end
                end
                ST_LATCH: begin
                    pending <= road_vec;
                    state   <= ST_READOUT;
                end
                ST_READOUT: begin
                    if (pend_any) begin
                        pending[pend_idx] <= 1'b0;
                    end else begin
                        state <= ST_ACCEPT;
                    end
                end
                default: state <= ST_ACCEPT;
            endcase
        end
    end

endmodule

// File: rtl/am_road_finder.sv
module am_road_finder
    import am_road_pkg::*;
#(
    parameter int unsigned NUM_PATTERNS = 16,
    localparam int unsigned PAT_W       = $clog2(NUM_PATTERNS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LAYER_W-1:0] in_layer,
    input  logic [COORD_W-1:0] in_coord,
    input  logic               in_last,
    input  logic               wr_en,
    input  logic [PAT_W-1:0]   wr_addr,
    input  logic [LAYER_W-1:0] wr_layer,
    input  logic [SS_W-1:0]    wr_ss,
    input  logic [CNT_W-1:0]   threshold,
    output logic               road_valid,
    output logic [PAT_W-1:0]   road_id,
    output logic               done
);

    ss_hit_t                 hit;
    logic                    accept;
    logic                    clear_flags;
    logic [NUM_PATTERNS-1:0] road_vec;

    always_comb begin
        hit.layer = in_layer;
        hit.ss    = coord_to_ss(in_coord);
    end

    for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_pat
        am_pattern_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_addr == PAT_W'(p))),
            .wr_layer (wr_layer),
            .wr_ss    (wr_ss),
            .hit_en   (accept),
            .hit      (hit),
            .clear    (clear_flags),
            .threshold(threshold),
            .is_road  (road_vec[p])
        );
    end

    am_readout_ctrl #(
        .NUM_PATTERNS(NUM_PATTERNS),
        .PAT_W       (PAT_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .road_vec   (road_vec),
        .in_ready   (in_ready),
        .accept     (accept),
        .clear_flags(clear_flags),
        .road_valid (road_valid),
        .road_id    (road_id),
        .done       (done)
    );

endmodule

// File: rtl/am_road_finder_chk.sv
module am_road_finder_chk #(
    parameter int unsigned PAT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             road_valid,
    input logic [PAT_W-1:0] road_id,
    input logic             done
);

    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (in_ready && !road_valid && !done));

    p_stall_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready);

    p_no_ready_in_readout_r7: assert property (@(posedge clk) disable iff (rst)
        (road_valid || done) |-> !in_ready);

    p_ascending_ids_r5: assert property (@(posedge clk) disable iff (rst)
        (road_valid && $past(road_valid)) |-> (road_id > $past(road_id)));

    p_road_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(road_valid && done));

    p_done_then_ready_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && in_ready));

endmodule

bind am_road_finder am_road_finder_chk #(
    .PAT_W(PAT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .road_valid(road_valid),
    .road_id   (road_id),
    .done      (done)
);

// File: tb/am_road_finder_tb_top.sv
`timescale 1ns/1ps
module am_road_finder_tb_top;

    localparam int NP = 16;
    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_layer = '0;
    logic [11:0] in_coord = '0;
    logic        in_last = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [2:0]  wr_layer = '0;
    logic [7:0]  wr_ss = '0;
    logic [3:0]  threshold = 4'd8;
    logic        road_valid;
    logic [3:0]  road_id;
    logic        done;

    int checks = 0;
    int failures = 0;
    int exp_q[$];
    int done_seen = 0;
    int road_seen = 0;
    logic [7:0] mdl_ss [NP][NL];
    logic [NL-1:0] mdl_flag [NP];

    always #2.5 clk = ~clk;

    am_road_finder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_layer(in_layer), .in_coord(in_coord), .in_last(in_last),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_layer(wr_layer), .wr_ss(wr_ss),
        .threshold(threshold), .road_valid(road_valid), .road_id(road_id),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (road_valid) begin
                road_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected road", int'(road_id), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(road_id) == e, "R4/R5 road id", int'(road_id), e);
                end
                chk(!in_ready, "R7 ready during readout", int'(in_ready), 0);
            end
            if (done) begin
                done_seen++;
                chk(exp_q.size() == 0, "R5/R9 roads missing at done", exp_q.size(), 0);
                exp_q.delete();
            end
        end
    end

    function automatic int ss_of(input int p, input int l);
        return p * 8 + l + 1;
    endfunction

    task automatic write_entry(input int p, input int l, input int ss);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(p); wr_layer = 3'(l); wr_ss = 8'(ss);
        mdl_ss[p][l] = 8'(ss);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // junk: keep offering a matching closing hit during readout (R7)
    task automatic send_hit(input int l, input int coord, input bit last, input bit junk);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_layer = 3'(l); in_coord = 12'(coord); in_last = last;
        @(posedge clk);
        for (int p = 0; p < NP; p++) begin
            if (mdl_ss[p][l] == 8'(coord >> 4)) mdl_flag[p][l] = 1'b1;
        end
        #1;
        in_valid = 1'b0; in_last = 1'b0;
        if (last) begin
            int dn;
            for (int p = 0; p < NP; p++) begin
                if ($countones(mdl_flag[p]) >= int'(threshold)) exp_q.push_back(p);
                mdl_flag[p] = '0;
            end
            dn = done_seen;
            if (junk) begin
                in_valid = 1'b1; in_layer = 3'd3; in_coord = 12'(ss_of(1, 3) << 4);
                in_last = 1'b1;
            end
            @(negedge clk);
            chk(!road_valid && !done && !in_ready, "R7 gap cycle after last",
                int'({road_valid, done, in_ready}), 0);
            @(negedge clk);
            chk(road_valid || done, "R5 readout start", int'({road_valid, done}), 1);
            while (!done) @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            @(negedge clk);
            chk(in_ready && !done, "R6 ready after done", int'(in_ready), 1);
            chk(done_seen == dn + 1, "R5 single done", done_seen - dn, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int r0;
        for (int p = 0; p < NP; p++) begin
            mdl_flag[p] = '0;
            for (int l = 0; l < NL; l++) mdl_ss[p][l] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready && !road_valid && !done, "R1 reset state",
            int'({in_ready, road_valid, done}), 4);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready && !road_valid && !done, "R1 after reset",
            int'({in_ready, road_valid, done}), 4);

        // R8: load the bank
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) write_entry(p, l, ss_of(p, l));

        // E1: full match of pattern 3, closing hit needed (R10, R2)
        threshold = 4'd8;
        for (int l = 0; l < NL; l++)
            send_hit(l, (ss_of(3, l) << 4) | l, l == NL - 1, 1'b0);

        // E2: threshold 7, pattern 9 full, 5 seven layers, 2 six layers (R4, R5 order)
        threshold = 4'd7;
        for (int l = 0; l < NL; l++) send_hit(l, ss_of(9, l) << 4, 1'b0, 1'b0);
        for (int l = 0; l < 7; l++) send_hit(l, (ss_of(5, l) << 4) | 15, 1'b0, 1'b0);
        for (int l = 0; l < 5; l++) send_hit(l, ss_of(2, l) << 4, 1'b0, 1'b0);
        r0 = road_seen;
        send_hit(5, ss_of(2, 5) << 4, 1'b1, 1'b0);
        chk(road_seen - r0 == 2, "R4 seven fires six does not", road_seen - r0, 2);

        // E3: R3 sticky duplicates on layer 0 count once, six layers -> none (R9)
        r0 = road_seen;
        send_hit(0, (ss_of(4, 0) << 4) | 1, 1'b0, 1'b0);
        send_hit(0, (ss_of(4, 0) << 4) | 7, 1'b0, 1'b0);
        send_hit(0, (ss_of(4, 0) << 4) | 14, 1'b0, 1'b0);
        for (int l = 1; l < 6; l++)
            send_hit(l, ss_of(4, l) << 4, l == 5, 1'b0);
        chk(road_seen == r0, "R3/R9 duplicates count once", road_seen - r0, 0);

        // E4: R8 rewrite pattern 0 layer 2; old value no longer matches
        threshold = 4'd8;
        write_entry(0, 2, 200);
        r0 = road_seen;
        for (int l = 0; l < NL; l++)
            send_hit(l, ss_of(0, l) << 4, l == NL - 1, 1'b0);
        chk(road_seen == r0, "R8 old value gone", road_seen - r0, 0);
        r0 = road_seen;
        for (int l = 0; l < NL; l++)
            send_hit(l, ((l == 2) ? 200 : ss_of(0, l)) << 4, l == NL - 1, 1'b0);
        chk(road_seen - r0 == 1, "R8 new value matches", road_seen - r0, 1);

        // E5: R7 offered hits during readout ignored
        threshold = 4'd2;
        send_hit(0, ss_of(1, 0) << 4, 1'b0, 1'b0);
        r0 = road_seen;
        send_hit(1, ss_of(6, 1) << 4, 1'b1, 1'b1);
        chk(road_seen == r0, "R7 first event", road_seen - r0, 0);
        r0 = road_seen;
        send_hit(0, ss_of(1, 0) << 4, 1'b1, 1'b0);
        chk(road_seen == r0, "R6/R7 no leak into next event", road_seen - r0, 0);

        // E6: threshold 0, every pattern is a road in ascending order (R4, R5)
        threshold = 4'd0;
        r0 = road_seen;
        send_hit(7, 12'hFF0, 1'b1, 1'b0);
        chk(road_seen - r0 == NP, "R4 threshold zero all roads", road_seen - r0, NP);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule